// File: doc/BRIEF.md
# CAN Transmit-Path Fault Protection Controller

This synchronous controller sits between a CAN host's transmit bit and the driver stage of a CAN physical layer. It decides, on every clock, whether the driver may pull the bus dominant. Three independent fault sources can remove that permission, and each has its own recovery rule. A watchdog fires when the transmit input stays low too long and clears only when the input returns high. A thermal monitor trips on a digital junction-temperature code and releases only below a hysteresis band. A supply guard reacts to logic-side and bus-side undervoltage flags and restores normal operation only after a timed re-enable delay.

Each fault drives its own mix of bus and receive states. A stuck-dominant fault or an over-temperature fault forces the bus recessive while the receive bit keeps tracking the bus comparator. A logic-side undervoltage holds the bus recessive and parks the receive bit high. A bus-side undervoltage floats the bus outputs and also parks the receive bit high. The transmit input goes through a two-flop synchronizer. Time limits are given in microseconds and converted to clock cycles from the clock-frequency parameter. Temperature codes are degrees Celsius plus an offset (`TEMP_OFS`, default 50).

Top module: `can_txprot_ctrl`

## Requirements
- R1: `drv_dom_o` is 1 only when `drv_en_o` is 1 and the synchronized transmit level is low. The transmit input reaches `drv_dom_o` two clock edges after it is sampled.
- R2: After `DTO_US` worth of cycles (`DTO_CYC`) of continuously low synchronized transmit level, `dto_o` goes to 1 and `drv_en_o` goes to 0. The resulting limit lies inside 1.2 ms to 3.8 ms.
- R3: `dto_o` stays set while the transmit input stays low. It clears on the first cycle the synchronized level is high. A later falling edge starts a fresh full-length timeout.
- R4: While `dto_o` or `tsd_o` is set, `drv_dom_o` is 0. While neither supply flag was set on the previous edge, `rxd_o` equals the inverse of `bus_dom_i` sampled on the previous edge.
- R5: `tsd_o` sets on the edge after `temp_i` reaches the trip code (170 °C plus offset), and `drv_en_o` is then 0.
- R6: `tsd_o` clears only when `temp_i` is at or below the trip code minus 5 °C. Codes between the two thresholds hold the current state.
- R7: With `uv1_i` (logic-side undervoltage) set, the next cycle has `drv_en_o`=0, `drv_dom_o`=0, `bus_hiz_o`=0 (recessive bias) and `rxd_o`=1.
- R8: With `uv2_i` (bus-side undervoltage) set, the next cycle has `bus_hiz_o`=1, `drv_en_o`=0 and `rxd_o`=1.
- R9: `uvlo_o` stays 1 until both supply flags have been clear for `REEN_CYC` consecutive registered cycles (`REEN_US`, default 300 µs). A flag returning during the delay restarts the count.
- R10: After reset the block is protected: `uvlo_o`=1, `drv_en_o`=0, `drv_dom_o`=0, `rxd_o`=1, `dto_o`=0, `tsd_o`=0, `bus_hiz_o`=0.
- R11: Eleven consecutive dominant bits at `MIN_BITRATE` do not trigger the dominant timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Host transmit bit, 0 = dominant request |
| bus_dom_i | input | 1 | Receiver comparator flag, 1 = bus dominant |
| uv1_i | input | 1 | Logic-side supply undervoltage |
| uv2_i | input | 1 | Bus-side supply undervoltage |
| temp_i | input | TEMP_W | Junction temperature code, °C + TEMP_OFS |
| drv_en_o | output | 1 | Driver permitted to drive dominant |
| drv_dom_o | output | 1 | Dominant drive request to the driver |
| bus_hiz_o | output | 1 | Request high-impedance bus outputs |
| rxd_o | output | 1 | Receive bit to host, 0 = dominant |
| dto_o | output | 1 | Dominant timeout active |
| tsd_o | output | 1 | Thermal shutdown active |
| uvlo_o | output | 1 | Undervoltage or re-enable delay active |

## Verification
The assertions assume that the temperature code and supply flags are already synchronous to the clock and move only between clock edges. They also assume the bus-dominant flag is a clean registered-domain level. The bench drives every input on the falling clock edge, so each value is stable for a full cycle before it is sampled. It changes the temperature in steps that cross each threshold deliberately. It asserts a supply flag for at least one whole cycle. It sets the clock-frequency parameter to a scaled value so that the timeout and re-enable windows span a few hundred cycles, while the cycle-count relations the assertions check stay the same.

// File: rtl/can_txprot_pkg.sv
package can_txprot_pkg;

    typedef enum logic [1:0] {
        PG_HOLD = 2'd0,
        PG_WAIT = 2'd1,
        PG_RUN  = 2'd2
    } pgood_mode_e;

    function automatic int us_to_cycles(input int clk_hz, input int us);
        return (clk_hz / 1000) * us / 1000;
    endfunction

endpackage

// File: rtl/cantp_txd_sync.sv
module cantp_txd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    output logic tx_lvl_o
);
    typedef struct packed {
        logic meta;
        logic sync;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = txd_i;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: 1'b1, sync: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_lvl_o = st_q.sync;
endmodule

// File: rtl/cantp_dom_timer.sv
module cantp_dom_timer #(
    parameter int LIMIT = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_lvl_i,
    output logic fault_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fault;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tx_lvl_i) begin
            st_d.cnt   = '0;
            st_d.fault = 1'b0;
        end else if (!st_q.fault) begin
            if (st_q.cnt == CW'(LIMIT - 1)) begin
                st_d.fault = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.fault;
endmodule

// File: rtl/cantp_thermal.sv
module cantp_thermal #(
    parameter int TW       = 8,
    parameter int TRIP_C   = 220,
    parameter int RELEASE_C = 215
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_i,
    output logic          tsd_o
);
    typedef struct packed {
        logic tsd;
    } th_s;

    th_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (temp_i >= TW'(TRIP_C)) begin
            st_d.tsd = 1'b1;
        end else if (temp_i <= TW'(RELEASE_C)) begin
            st_d.tsd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tsd_o = st_q.tsd;
endmodule

// File: rtl/cantp_supply_guard.sv
module cantp_supply_guard
    import can_txprot_pkg::*;
#(
    parameter int DELAY = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv1_i,
    input  logic uv2_i,
    output logic lv_low_o,
    output logic bv_low_o,
    output logic ready_o
);
    localparam int CW = $clog2(DELAY + 1);

    typedef struct packed {
        logic          lv;
        logic          bv;
        pgood_mode_e   mode;
        logic [CW-1:0] cnt;
    } pg_s;

    pg_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.lv = uv1_i;
        st_d.bv = uv2_i;
        if (st_q.lv || st_q.bv) begin
            st_d.mode = PG_HOLD;
            st_d.cnt  = '0;
        end else if (st_q.mode != PG_RUN) begin
            if (st_q.cnt == CW'(DELAY - 1)) begin
                st_d.mode = PG_RUN;
                st_d.cnt  = '0;
            end else begin
                st_d.mode = PG_WAIT;
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lv: 1'b0, bv: 1'b0, mode: PG_HOLD, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lv_low_o = st_q.lv;
    assign bv_low_o = st_q.bv;
    assign ready_o  = (st_q.mode == PG_RUN);
endmodule

// File: rtl/can_txprot_ctrl.sv
module can_txprot_ctrl
    import can_txprot_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 200_000_000,
    parameter int DTO_US      = 2000,
    parameter int REEN_US     = 300,
    parameter int MIN_BITRATE = 10_000,
    parameter int TEMP_W      = 8,
    parameter int TEMP_OFS    = 50,
    parameter int TSD_TRIP_C  = 170,
    parameter int TSD_HYST_C  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txd_i,
    input  logic              bus_dom_i,
    input  logic              uv1_i,
    input  logic              uv2_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              drv_en_o,
    output logic              drv_dom_o,
    output logic              bus_hiz_o,
    output logic              rxd_o,
    output logic              dto_o,
    output logic              tsd_o,
    output logic              uvlo_o
);
    localparam int DTO_CYC   = us_to_cycles(CLK_FREQ_HZ, DTO_US);
    localparam int REEN_CYC  = us_to_cycles(CLK_FREQ_HZ, REEN_US);
    localparam int TRIP_CODE = TSD_TRIP_C + TEMP_OFS;
    localparam int REL_CODE  = TRIP_CODE - TSD_HYST_C;

    logic tx_lvl, dto_flt, tsd_flt, lv_low, bv_low, pg_ready;

    cantp_txd_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .txd_i    (txd_i),
        .tx_lvl_o (tx_lvl)
    );

    cantp_dom_timer #(.LIMIT(DTO_CYC)) u_dto (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_lvl_i (tx_lvl),
        .fault_o  (dto_flt)
    );

    cantp_thermal #(
        .TW        (TEMP_W),
        .TRIP_C    (TRIP_CODE),
        .RELEASE_C (REL_CODE)
    ) u_tsd (
        .clk    (clk),
        .rst_n  (rst_n),
        .temp_i (temp_i),
        .tsd_o  (tsd_flt)
    );

    cantp_supply_guard #(.DELAY(REEN_CYC)) u_pg (
        .clk      (clk),
        .rst_n    (rst_n),
        .uv1_i    (uv1_i),
        .uv2_i    (uv2_i),
        .lv_low_o (lv_low),
        .bv_low_o (bv_low),
        .ready_o  (pg_ready)
    );

    typedef struct packed {
        logic bus_dom;
    } rx_s;

    rx_s rx_d, rx_q;

    always_comb begin
        rx_d         = rx_q;
        rx_d.bus_dom = bus_dom_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    logic permit;

    always_comb begin
        permit    = pg_ready && !lv_low && !bv_low && !dto_flt && !tsd_flt;
        drv_en_o  = permit;
        drv_dom_o = permit && !tx_lvl;
        bus_hiz_o = bv_low;
        rxd_o     = (lv_low || bv_low) ? 1'b1 : !rx_q.bus_dom;
        dto_o     = dto_flt;
        tsd_o     = tsd_flt;
        uvlo_o    = !pg_ready;
    end
endmodule

// File: rtl/cantp_chk.sv
module cantp_chk #(
    parameter int CLK_FREQ_HZ = 200_000_000,
    parameter int MIN_BITRATE = 10_000,
    parameter int REEN_CYC    = 60000,
    parameter int TRIP_CODE   = 220,
    parameter int REL_CODE    = 215,
    parameter int TEMP_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd_i,
    input logic              bus_dom_i,
    input logic              uv1_i,
    input logic              uv2_i,
    input logic [TEMP_W-1:0] temp_i,
    input logic              drv_en_o,
    input logic              drv_dom_o,
    input logic              bus_hiz_o,
    input logic              rxd_o,
    input logic              dto_o,
    input logic              tsd_o,
    input logic              uvlo_o
);
    localparam int KHZ     = CLK_FREQ_HZ / 1000;
    localparam int WIN_LO  = KHZ * 1200 / 1000;
    localparam int WIN_HI  = KHZ * 3800 / 1000 + 2;
    localparam int MIN_RUN = 11 * (CLK_FREQ_HZ / MIN_BITRATE);

    int unsigned low_run;
    int unsigned clr_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
            clr_run <= 0;
        end else begin
            low_run <= txd_i ? 0 : ((low_run == 32'hFFFF_FFFF) ? low_run : low_run + 1);
            clr_run <= (uv1_i || uv2_i) ? 0 :
                       ((clr_run == 32'hFFFF_FFFF) ? clr_run : clr_run + 1);
        end
    end

    assert_drive_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom_o |-> (drv_en_o && $past(txd_i, 2) == 1'b0));

    assert_dto_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dto_o) |-> (low_run >= WIN_LO && low_run <= WIN_HI));

    assert_dto_eleven_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dto_o) |-> (low_run > MIN_RUN));

    assert_dto_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dto_o) |-> $past(txd_i, 3));

    assert_fault_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dto_o || tsd_o) |-> !drv_dom_o);

    assert_rx_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(uv1_i) && !$past(uv2_i)) |-> (rxd_o == !$past(bus_dom_i)));

    assert_tsd_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(temp_i) >= TRIP_CODE) |-> (tsd_o && !drv_en_o));

    assert_tsd_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tsd_o) |-> ($past(temp_i) <= REL_CODE));

    assert_logic_uv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv1_i) |-> (!drv_dom_o && !drv_en_o && rxd_o));

    assert_bus_uv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv2_i) |-> (bus_hiz_o && !drv_en_o && rxd_o));

    assert_reenable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uvlo_o) |-> (clr_run >= REEN_CYC));
endmodule

bind can_txprot_ctrl cantp_chk #(
    .CLK_FREQ_HZ (CLK_FREQ_HZ),
    .MIN_BITRATE (MIN_BITRATE),
    .REEN_CYC    (REEN_CYC),
    .TRIP_CODE   (TRIP_CODE),
    .REL_CODE    (REL_CODE),
    .TEMP_W      (TEMP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd_i     (txd_i),
    .bus_dom_i (bus_dom_i),
    .uv1_i     (uv1_i),
    .uv2_i     (uv2_i),
    .temp_i    (temp_i),
    .drv_en_o  (drv_en_o),
    .drv_dom_o (drv_dom_o),
    .bus_hiz_o (bus_hiz_o),
    .rxd_o     (rxd_o),
    .dto_o     (dto_o),
    .tsd_o     (tsd_o),
    .uvlo_o    (uvlo_o)
);

// File: tb/tb_can_txprot_ctrl.sv
`timescale 1ns/1ps
module tb_can_txprot_ctrl;
    localparam int CLKHZ   = 200_000;
    localparam int T_DTO   = 400;
    localparam int T_REEN  = 60;
    localparam int BITC    = 20;
    localparam int TRIP    = 220;
    localparam int REL     = 215;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1, busd = 1'b0, uv1 = 1'b0, uv2 = 1'b0;
    logic [7:0] temp = 8'd75;
    logic drv_en, drv_dom, hiz, rxd, dto, tsd, uvlo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    can_txprot_ctrl #(
        .CLK_FREQ_HZ (CLKHZ),
        .DTO_US      (2000),
        .REEN_US     (300),
        .MIN_BITRATE (10_000)
    ) dut (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .bus_dom_i(busd),
        .uv1_i(uv1), .uv2_i(uv2), .temp_i(temp),
        .drv_en_o(drv_en), .drv_dom_o(drv_dom), .bus_hiz_o(hiz),
        .rxd_o(rxd), .dto_o(dto), .tsd_o(tsd), .uvlo_o(uvlo)
    );

    // behavioural reference
    bit   m_meta = 1, m_sync = 1, m_dto = 0, m_tsd = 0, m_lv = 0, m_bv = 0, m_bus = 0, m_rdy = 0;
    int   m_low = 0, m_clr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_meta = 1; m_sync = 1; m_dto = 0; m_tsd = 0; m_lv = 0; m_bv = 0;
            m_bus = 0; m_rdy = 0; m_low = 0; m_clr = 0;
        end else begin
            if (m_sync) m_low = 0;
            else if (m_low < T_DTO) m_low = m_low + 1;
            m_dto = (m_low >= T_DTO);
            m_sync = m_meta;
            m_meta = txd;
            if (temp >= TRIP) m_tsd = 1;
            else if (temp <= REL) m_tsd = 0;
            if (m_lv || m_bv) begin
                m_clr = 0; m_rdy = 0;
            end else if (!m_rdy) begin
                m_clr = m_clr + 1;
                m_rdy = (m_clr >= T_REEN);
            end
            m_lv = uv1; m_bv = uv2; m_bus = busd;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit en;
            en = m_rdy && !m_lv && !m_bv && !m_dto && !m_tsd;
            chk("R1", "drv_en", drv_en, en);
            chk("R1", "drv_dom", drv_dom, en && !m_sync);
            chk("R2", "dto", dto, m_dto);
            chk("R5", "tsd", tsd, m_tsd);
            chk("R8", "bus_hiz", hiz, m_bv);
            chk("R4", "rxd", rxd, (m_lv || m_bv) ? 1 : !m_bus);
            chk("R9", "uvlo", uvlo, !m_rdy);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        txd = b; busd = !b;
        step(BITC);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        step(4);
        // R10: protected state in and after reset
        chk("R10", "uvlo at reset", uvlo, 1);
        chk("R10", "rxd at reset", rxd, 1);
        chk("R10", "drv_en at reset", drv_en, 0);
        rst_n = 1'b1;
        step(2);
        txd = 0; busd = 1;
        step(4);
        chk("R10", "no drive before re-enable", drv_dom, 0);
        txd = 1; busd = 0;
        step(T_REEN + 2);
        chk("R9", "ready after delay", uvlo, 0);

        // normal traffic patterns
        for (int i = 0; i < 24; i++) send_bit(((i * 7) % 5) > 1);
        txd = 0; busd = 1;
        step(3);
        chk("R1", "dominant request passes", drv_dom, 1);
        txd = 1; busd = 0;
        step(3);
        chk("R1", "recessive request", drv_dom, 0);

        // R11: eleven dominant bits
        for (int i = 0; i < 11; i++) send_bit(0);
        chk("R11", "no timeout after 11 bits", dto, 0);
        send_bit(1);

        // R2: stuck dominant
        txd = 0; busd = 1;
        step(T_DTO + 1);
        chk("R2", "timeout not yet", dto, 0);
        step(2);
        chk("R2", "timeout set", dto, 1);
        chk("R4", "bus recessive in timeout", drv_dom, 0);
        busd = 0;
        step(2);
        chk("R4", "rxd follows bus in timeout", rxd, 1);
        busd = 1;
        step(2);
        chk("R4", "rxd follows bus dominant", rxd, 0);
        step(50);
        chk("R3", "timeout held while low", dto, 1);
        txd = 1; busd = 0;
        step(3);
        chk("R3", "timeout cleared by high", dto, 0);
        txd = 0; busd = 1;
        step(300);
        chk("R3", "fresh timer after new edge", dto, 0);
        chk("R3", "driving again", drv_dom, 1);
        txd = 1; busd = 0;
        step(3);

        // thermal
        temp = 8'd219; step(2);
        chk("R5", "below trip", tsd, 0);
        temp = 8'd220; step(1);
        chk("R5", "trip", tsd, 1);
        txd = 0; busd = 1; step(3);
        chk("R4", "no drive during thermal", drv_dom, 0);
        chk("R4", "rxd during thermal", rxd, 0);
        txd = 1; busd = 0;
        temp = 8'd217; step(3);
        chk("R6", "inside hysteresis holds", tsd, 1);
        temp = 8'd216; step(2);
        chk("R6", "still held at 216", tsd, 1);
        temp = 8'd215; step(1);
        chk("R6", "release", tsd, 0);
        temp = 8'd80; step(2);

        // logic-side undervoltage
        busd = 1;
        uv1 = 1; step(1);
        chk("R7", "lv rxd high", rxd, 1);
        chk("R7", "lv not hiz", hiz, 0);
        chk("R7", "lv driver off", drv_en, 0);
        step(8);
        uv1 = 0; busd = 0;
        step(30);
        chk("R9", "still in delay", uvlo, 1);
        // bus-side undervoltage during delay restarts it
        uv2 = 1; step(1);
        chk("R8", "bv hiz", hiz, 1);
        chk("R8", "bv rxd high", rxd, 1);
        step(4);
        uv2 = 0;
        step(T_REEN - 5);
        chk("R9", "restarted delay not done", uvlo, 1);
        step(10);
        chk("R9", "re-enabled", uvlo, 0);

        for (int i = 0; i < 10; i++) send_bit(i[0]);
        send_bit(1);
        step(5);
        finish_run();
    end
endmodule